// File: doc/BRIEF.md
# Hall Commutation and PWM Gating

This block turns three digital Hall sensor levels into switch enables for the three half-bridges of a brushless motor. Each of the six legal Hall codes selects one phase to source current (high-side switch on) and one phase to sink it (low-side switch on). Reverse rotation uses the same selection table addressed by the bit-inverted Hall code. The Hall and direction inputs are first brought into the clock domain by a two-flop synchronizer.

Motor power is regulated by chopping the low-side switch of the active pair with a PWM signal. The high-side switch stays on for the whole commutation step. A small carrier counter compares against a duty input to make this PWM signal. A cycle-by-cycle current-limit input cuts the active sink for the rest of the current carrier period. A protection-trip input forces all low-side switches off. A stop input turns every switch off. All six enables come from registers.

Top module: `bldc_commutator`

## Requirements
- R1: With `dir_rev`=0, the Hall code written as (`hall_in[2]`,`hall_in[1]`,`hall_in[0]`) maps to a source/sink phase pair as follows: 101 gives 2/1, 100 gives 3/1, 110 gives 3/2, 010 gives 1/2, 011 gives 1/3 and 001 gives 2/3. Phase n is bit n-1 of `src_en` and `snk_en`.
- R2: With `dir_rev`=1, the pair is the one R1 gives for the bitwise complement of the Hall code.
- R3: The Hall codes 000 and 111 drive all six enables low, in either direction.
- R4: When `run_en` is low at a clock edge, all six enables are low after that edge.
- R5: The carrier period is 2^CNT_W cycles. In each period the active sink is enabled for exactly `duty` cycles, clamped to the period, so 0 means never and 2^CNT_W means always. The active source stays enabled for every cycle of the period.
- R6: When `ilim` is high at an edge, the sink enables are low after that edge. They stay low until the first edge at which the carrier restarts its period. The source enable is not affected.
- R7: When `trip` is high at an edge, the sink enables are low after that edge, and the source enable is unchanged.
- R8: At most one bit of `src_en` is high and at most one bit of `snk_en` is high. No phase ever has both its enables high. A sink is only ever enabled together with a source.
- R9: A change on `hall_in` or `dir_rev` shows at the outputs after the third rising edge that follows it, and not before.
- R10: While `rst` is high, all enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | 1 = run, 0 = stop (all switches off) |
| dir_rev | input | 1 | 0 = forward, 1 = reverse (asynchronous, synchronized) |
| hall_in | input | 3 | Hall levels; bit 2 = sensor 1, bit 0 = sensor 3 (asynchronous) |
| duty | input | CNT_W+1 | Sink on-cycles per carrier period |
| ilim | input | 1 | Current limit reached |
| trip | input | 1 | Protection trip, forces low sides off |
| src_en | output | 3 | High-side enables, bit n-1 = phase n |
| snk_en | output | 3 | Low-side enables, bit n-1 = phase n |

## Verification
The bench walks all six legal codes in both directions and checks each source/sink pair. A mis-wired table or a reversal done by reordering the sequence, instead of complementing the code, would show up as a wrong phase pair. It applies the two illegal codes, where a naive decoder would leave an old pair on or turn on a shoot-through pair. It also counts sink cycles across a whole carrier period at zero, partial and full duty, which catches off-by-one compares and a source that gets chopped. It pulses the current limit early in a period and expects the sink to stay dark until the next period start. A design that re-enables on the next PWM-on cycle, or that blanks the source, fails this check. The synchronizer latency is checked cycle by cycle on one Hall transition.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;

    localparam int NUM_PHASES = 3;

    typedef logic [NUM_PHASES-1:0] phase_vec_t;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } dir_e;

    typedef struct packed {
        phase_vec_t src;
        phase_vec_t snk;
    } bridge_cmd_t;

    localparam phase_vec_t PH_1 = 3'b001;
    localparam phase_vec_t PH_2 = 3'b010;
    localparam phase_vec_t PH_3 = 3'b100;

    // Six-step table; reverse rotation addresses it with the inverted code.
    function automatic bridge_cmd_t hall_to_cmd(input logic [2:0] code, input dir_e dir);
        logic [2:0]  eff;
        bridge_cmd_t c;
        eff = (dir == DIR_REV) ? ~code : code;
        c   = '0;
        case (eff)
            3'b101:  c = '{src: PH_2, snk: PH_1};
            3'b100:  c = '{src: PH_3, snk: PH_1};
            3'b110:  c = '{src: PH_3, snk: PH_2};
            3'b010:  c = '{src: PH_1, snk: PH_2};
            3'b011:  c = '{src: PH_1, snk: PH_3};
            3'b001:  c = '{src: PH_2, snk: PH_3};
            default: c = '0; // 000 / 111 are illegal (R3)
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bldc_sync.sv
module bldc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bldc_pwm_gate.sv
module bldc_pwm_gate #(
    parameter int CNT_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CNT_W:0] duty,
    input  logic           ilim,
    output logic           chop_ok
);
    localparam logic [CNT_W-1:0] LAST = '1;

    logic [CNT_W-1:0] cnt;
    logic             lim_hold;
    logic             pwm_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            lim_hold <= 1'b0;
        end else begin
            cnt      <= cnt + 1'b1;
            // Hold the cut until the carrier wraps to a new period.
            lim_hold <= (cnt == LAST) ? 1'b0 : (lim_hold | ilim);
        end
    end

    assign pwm_on  = ({1'b0, cnt} < duty);
    assign chop_ok = pwm_on & ~ilim & ~lim_hold;
endmodule

// File: rtl/bldc_comm_decode.sv
module bldc_comm_decode
    import bldc_comm_pkg::*;
(
    input  logic [2:0]  hall_code,
    input  logic        dir_rev,
    output bridge_cmd_t cmd
);
    always_comb begin
        cmd = hall_to_cmd(hall_code, dir_e'(dir_rev));
    end
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
    import bldc_comm_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run_en,
    input  logic           dir_rev,
    input  logic [2:0]     hall_in,
    input  logic [CNT_W:0] duty,
    input  logic           ilim,
    input  logic           trip,
    output logic [2:0]     src_en,
    output logic [2:0]     snk_en
);
    localparam int SYNC_W = NUM_PHASES + 1;

    logic [SYNC_W-1:0] sync_q;
    logic [2:0]        hall_q;
    logic              dir_q;
    logic              chop_ok;
    bridge_cmd_t       cmd;
    phase_vec_t        src_q, snk_q;

    bldc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dir_rev, hall_in}),
        .q   (sync_q)
    );

    assign hall_q = sync_q[2:0];
    assign dir_q  = sync_q[3];

    bldc_comm_decode u_dec (
        .hall_code (hall_q),
        .dir_rev   (dir_q),
        .cmd       (cmd)
    );

    bldc_pwm_gate #(.CNT_W(CNT_W)) u_pwm (
        .clk     (clk),
        .rst     (rst),
        .duty    (duty),
        .ilim    (ilim),
        .chop_ok (chop_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            snk_q <= '0;
        end else begin
            src_q <= run_en ? cmd.src : '0;
            snk_q <= (run_en && !trip && chop_ok) ? cmd.snk : '0;
        end
    end

    assign src_en = src_q;
    assign snk_en = snk_q;
endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk (
    input logic       clk,
    input logic       rst,
    input logic       run_en,
    input logic       ilim,
    input logic       trip,
    input logic [2:0] hall_q,
    input logic [2:0] src_en,
    input logic [2:0] snk_en
);
    assert_src_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_en));
    assert_snk_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(snk_en));
    assert_no_shoot_R8: assert property (@(posedge clk) disable iff (rst)
        (src_en & snk_en) == 3'b000);
    assert_sink_needs_src_R8: assert property (@(posedge clk) disable iff (rst)
        (snk_en != 3'b000) |-> (src_en != 3'b000));
    assert_stop_off_R4: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (src_en == 3'b000 && snk_en == 3'b000));
    assert_trip_sink_off_R7: assert property (@(posedge clk) disable iff (rst)
        trip |=> (snk_en == 3'b000));
    assert_ilim_cut_R6: assert property (@(posedge clk) disable iff (rst)
        ilim |=> (snk_en == 3'b000));
    assert_illegal_off_R3: assert property (@(posedge clk) disable iff (rst)
        (hall_q == 3'b000 || hall_q == 3'b111) |=> (src_en == 3'b000 && snk_en == 3'b000));
endmodule

bind bldc_commutator bldc_commutator_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .run_en (run_en),
    .ilim   (ilim),
    .trip   (trip),
    .hall_q (hall_q),
    .src_en (src_en),
    .snk_en (snk_en)
);

// File: tb/test_bldc_commutator.sv
module test_bldc_commutator;
    localparam int CW     = 4;
    localparam int PERIOD = 1 << CW;

    logic          clk = 1'b0;
    logic          rst, run_en, dir_rev, ilim, trip;
    logic [2:0]    hall_in;
    logic [CW:0]   duty;
    logic [2:0]    src_en, snk_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0] s;
        logic [2:0] k;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    bldc_commutator #(.CNT_W(CW)) i_bldc_commutator (
        .clk(clk), .rst(rst), .run_en(run_en), .dir_rev(dir_rev),
        .hall_in(hall_in), .duty(duty), .ilim(ilim), .trip(trip),
        .src_en(src_en), .snk_en(snk_en)
    );

    // R1 table: {source, sink}
    function automatic logic [5:0] fwd_pair(input logic [2:0] c);
        case (c)
            3'b101:  return {3'b010, 3'b001};
            3'b100:  return {3'b100, 3'b001};
            3'b110:  return {3'b100, 3'b010};
            3'b010:  return {3'b001, 3'b010};
            3'b011:  return {3'b001, 3'b100};
            3'b001:  return {3'b010, 3'b100};
            default: return 6'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Driver side of the scoreboard: item is compared at the next negedge.
    task automatic expect_now(input logic [5:0] p, input string tag);
        item_t it;
        it.s = p[5:3]; it.k = p[2:0]; it.tag = tag;
        sb_q.push_back(it);
        step(1);
    endtask

    task automatic apply_hall(input logic [2:0] c);
        hall_in = c;
        step(2);
    endtask

    // Monitor
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (src_en !== it.s || snk_en !== it.k) begin
                    errors++;
                    $display("FAIL %s: got src=%b snk=%b expected src=%b snk=%b",
                             it.tag, src_en, snk_en, it.s, it.k);
                end
                checks++;
                if (!$onehot0(src_en) || !$onehot0(snk_en) || (src_en & snk_en) != 0) begin
                    errors++;
                    $display("FAIL R8 (%s): got src=%b snk=%b expected one-hot, disjoint",
                             it.tag, src_en, snk_en);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] fwd_codes [6];
        int hi, shi, cnt;
        bit prev, found;
        fwd_codes = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};

        rst = 1'b1; run_en = 1'b1; dir_rev = 1'b0; hall_in = 3'b101;
        duty = (CW+1)'(PERIOD); ilim = 1'b0; trip = 1'b0;
        step(1);
        expect_now(6'b0, "R10 reset state");
        rst = 1'b0;
        step(3);
        expect_now(fwd_pair(3'b101), "R1 fwd 101");

        // R9: latency of one Hall change
        hall_in = 3'b100;
        expect_now(fwd_pair(3'b101), "R9 hold after edge 1");
        expect_now(fwd_pair(3'b101), "R9 hold after edge 2");
        expect_now(fwd_pair(3'b100), "R9 new after edge 3");

        for (int i = 0; i < 6; i++) begin
            apply_hall(fwd_codes[i]);
            expect_now(fwd_pair(fwd_codes[i]), $sformatf("R1 fwd %b", fwd_codes[i]));
        end

        dir_rev = 1'b1;
        for (int i = 0; i < 6; i++) begin
            apply_hall(fwd_codes[i]);
            expect_now(fwd_pair(~fwd_codes[i]), $sformatf("R2 rev %b", fwd_codes[i]));
        end

        apply_hall(3'b000); expect_now(6'b0, "R3 rev 000");
        apply_hall(3'b111); expect_now(6'b0, "R3 rev 111");
        dir_rev = 1'b0;
        apply_hall(3'b000); expect_now(6'b0, "R3 fwd 000");
        apply_hall(3'b111); expect_now(6'b0, "R3 fwd 111");

        apply_hall(3'b101);
        expect_now(fwd_pair(3'b101), "R1 fwd 101 restore");

        run_en = 1'b0;
        expect_now(6'b0, "R4 stop");
        run_en = 1'b1;
        expect_now(fwd_pair(3'b101), "R4 restart");

        trip = 1'b1;
        expect_now({3'b010, 3'b000}, "R7 trip");
        trip = 1'b0;
        expect_now(fwd_pair(3'b101), "R7 release");

        // R5: duty counting over one full period
        for (int d = 0; d < 3; d++) begin
            duty = (d == 0) ? (CW+1)'(5) : (d == 1) ? (CW+1)'(0) : (CW+1)'(PERIOD);
            step(3);
            hi = 0; shi = 0;
            for (int c = 0; c < PERIOD; c++) begin
                step(1);
                if (snk_en == 3'b001) hi++;
                if (src_en == 3'b010) shi++;
            end
            chk($sformatf("R5 sink cycles duty=%0d", duty), hi, int'(duty));
            chk($sformatf("R5 source cycles duty=%0d", duty), shi, PERIOD);
        end

        // R6: current limit early in a period holds until the next period
        duty = (CW+1)'(8);
        step(2);
        found = 1'b0;
        for (int c = 0; c < 3 * PERIOD && !found; c++) begin
            prev = (snk_en != 0);
            step(1);
            if (!prev && snk_en != 0) found = 1'b1;
        end
        chk("R6 period start seen", int'(found), 1);
        cnt = 1;
        ilim = 1'b1;
        step(1);
        ilim = 1'b0;
        chk("R6 sink cut next cycle", int'(snk_en), 0);
        chk("R6 source kept", int'(src_en), 2);
        shi = (src_en == 3'b010) ? 1 : 0;
        for (int c = 0; c < PERIOD - 2; c++) begin
            step(1);
            if (snk_en != 0) cnt++;
            if (src_en == 3'b010) shi++;
        end
        chk("R6 sink cycles in limited period", cnt, 1);
        chk("R6 source cycles in limited period", shi, PERIOD - 1);
        step(1);
        chk("R6 sink back at next period", int'(snk_en), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule